// File: doc/BRIEF.md
# Indirect Channel RAM Access Controller

This block lets a host reach three per-channel RAM banks (channel data, receive configuration and transmit configuration) through just two host registers. One is a control word that names a channel, a bank and a direction. The other is a shared 16-bit data register. A write to the control word starts an indirect access. The block raises a busy flag for the whole access. When the access ends, it clears busy and, for a read, the fetched word is already in the data register.

Which channels are legal depends on the port's channelization mode. The port can be unchannelized, or it can carry a 24, 32, 64 or 128 channel frame. An access to an illegal bank select, or to a channel beyond the current mode's range, touches no RAM. It sets a sticky error flag, and the host clears that flag with a dedicated control write. While busy is high, the block ignores any host write, so an access in flight cannot be disturbed.

Top module: `ichram_ctrl`

## Requirements
- R1: After reset, busy and err are 0, the data register reads 0 and every RAM word reads 0.
- R2: A host write with hw_sel=0 while busy is 0 is a control write. Its fields are: channel at bits 6:0, bank at bits 9:8, direction at bit 14 (1 = read, 0 = write) and error-clear at bit 13. Bank codes are 0 = channel data, 1 = receive configuration, 2 = transmit configuration and 3 = illegal.
- R3: A host write with hw_sel=1 while busy is 0 loads hw_data into the data register.
- R4: A control write with bit 13 = 0 starts an access. busy reads 1 from the cycle after the write.
- R5: A legal write access stores the data register's value into the selected bank and channel. No other word changes.
- R6: A legal access keeps busy high for exactly 3 cycles.
- R7: A legal read access places the addressed word in the data register in the same cycle that busy falls.
- R8: The mode inputs set the legal channel range. mode_unch=1 allows no channel. With mode_unch=0, mode_sel values 0, 1, 2 and 3 allow channels 0 to 23, 0 to 31, 0 to 63 and 0 to 127.
- R9: An access with bank 3, or with a channel outside the range, writes no RAM and leaves the data register unchanged. It keeps busy high for exactly 1 cycle and then sets err.
- R10: err stays at 1 until a control write with bit 13 = 1 clears it. That write starts no access.
- R11: While busy is 1, host writes to either register are ignored.
- R12: ctrl_word reads back busy at bit 15, the latched direction at bit 14, err at bit 13, the latched bank at bits 9:8 and the latched channel at bits 6:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_unch | input | 1 | 1 = unchannelized port |
| mode_sel | input | 2 | Channelized rate select |
| hw_en | input | 1 | Host write strobe |
| hw_sel | input | 1 | 0 = control register, 1 = data register |
| hw_data | input | 16 | Host write value |
| data_reg | output | 16 | Shared data register |
| ctrl_word | output | 16 | Control and status readback |
| busy | output | 1 | Indirect access in progress |
| err | output | 1 | Sticky rejected-access flag |

## Verification
The assertions check four things on every cycle:
- an accepted start always raises busy;
- busy never lasts longer than the access latency;
- the data register and the latched fields hold still while busy stays high;
- err only falls on a clear write.

Other behaviour needs the bench's scenarios, because it depends on history:
- whether the right RAM word was written or returned, and which mode allowed which channel;
- that rejected accesses leave memory unchanged.

The bench checks these by comparing the design against its own memory and range model under random mode, bank and channel mixes, along with directed range edges and writes during busy.

// File: rtl/ichram_pkg.sv
// Package: shared constants and types for the indirect channel RAM controller.
// Assumes a 16-bit host word and at most 128 channels per bank.
package ichram_pkg;
    localparam int DW       = 16;
    localparam int NCH      = 128;
    localparam int CHW      = $clog2(NCH);
    localparam int NBANK    = 3;
    localparam int LATENCY  = 3;

    // Control word field positions
    localparam int F_CHAN_LO = 0;
    localparam int F_BANK_LO = 8;
    localparam int F_ECLR    = 13;
    localparam int F_DIR     = 14;
    localparam int F_BUSY    = 15;

    typedef enum logic [1:0] {
        BANK_DATA = 2'd0,
        BANK_RCFG = 2'd1,
        BANK_TCFG = 2'd2,
        BANK_BAD  = 2'd3
    } bank_e;
endpackage

// File: rtl/ichram_range.sv
// Module: ichram_range
// Decides whether a requested bank/channel pair is legal for the port mode.
// Assumes mode inputs are stable while a control write is presented.
module ichram_range
    import ichram_pkg::*;
#(
    parameter int CW = CHW
) (
    input  logic          mode_unch,
    input  logic [1:0]    mode_sel,
    input  logic [CW-1:0] chan,
    input  logic [1:0]    bank,
    output logic          legal
);
    localparam int LW = CW + 1;

    logic [LW-1:0] limit;

    // Channel count allowed by the present mode
    always_comb begin
        if (mode_unch) begin
            limit = '0;
        end else begin
            case (mode_sel)
                2'd0:    limit = LW'(24);
                2'd1:    limit = LW'(32);
                2'd2:    limit = LW'(64);
                default: limit = LW'(128);
            endcase
        end
    end

    // Legal when the bank exists and the channel is below the limit
    always_comb begin
        legal = (bank != BANK_BAD) && ({1'b0, chan} < limit);
    end
endmodule

// File: rtl/ichram_seq.sv
// Module: ichram_seq
// Sequences one indirect access: holds busy for LAT cycles on a legal access,
// or for one cycle on a rejected one, and pulses the finishing strobes.
// Assumes start is only asserted while busy is low.
module ichram_seq #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic legal,
    input  logic rd_req,
    output logic busy,
    output logic ram_we,
    output logic rd_load,
    output logic err_set
);
    localparam int CNTW = (LAT < 2) ? 1 : $clog2(LAT);

    logic            busy_q;
    logic [CNTW-1:0] cnt_q;
    logic            bad_q;
    logic            rd_q;
    logic            fin;

    assign fin = busy_q && (cnt_q == '0);

    // Busy flag, remaining-cycle counter and latched access kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            bad_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= legal ? CNTW'(LAT - 1) : '0;
            bad_q  <= !legal;
            rd_q   <= rd_req;
        end else if (fin) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Finishing strobes, valid in the last busy cycle
    always_comb begin
        busy    = busy_q;
        ram_we  = fin && !bad_q && !rd_q;
        rd_load = fin && !bad_q &&  rd_q;
        err_set = fin &&  bad_q;
    end
endmodule

// File: rtl/ichram_bank.sv
// Module: ichram_bank
// Behavioural per-channel RAM: asynchronous read, synchronous write,
// all words cleared by reset.
module ichram_bank #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Clear on reset, store on write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Combinational read port
    always_comb begin
        rdata = mem[addr];
    end
endmodule

// File: rtl/ichram_ctrl.sv
// Module: ichram_ctrl (top)
// Host-side indirect access to three per-channel RAM banks through one
// control word and one shared data register, with a busy handshake and
// mode-dependent channel range checking.
// Assumes a single host write port; host writes are ignored while busy.
module ichram_ctrl
    import ichram_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_unch,
    input  logic [1:0]    mode_sel,
    input  logic          hw_en,
    input  logic          hw_sel,
    input  logic [DW-1:0] hw_data,
    output logic [DW-1:0] data_reg,
    output logic [DW-1:0] ctrl_word,
    output logic          busy,
    output logic          err
);
    logic           ctrl_wr;
    logic           start;
    logic           eclr;
    logic           data_wr;
    logic           legal;
    logic           ram_we;
    logic           rd_load;
    logic           err_set;
    logic [CHW-1:0] chan_q;
    logic [1:0]     bank_q;
    logic           dir_q;
    logic [DW-1:0]  data_q;
    logic           err_q;
    logic [DW-1:0]  bank_rd [NBANK];
    logic [DW-1:0]  rd_mux;

    // Host write decode; everything gated by busy
    always_comb begin
        ctrl_wr = hw_en && !hw_sel && !busy;
        start   = ctrl_wr && !hw_data[F_ECLR];
        eclr    = ctrl_wr &&  hw_data[F_ECLR];
        data_wr = hw_en &&  hw_sel && !busy;
    end

    ichram_range #(.CW(CHW)) u_range (
        .mode_unch (mode_unch),
        .mode_sel  (mode_sel),
        .chan      (hw_data[F_CHAN_LO +: CHW]),
        .bank      (hw_data[F_BANK_LO +: 2]),
        .legal     (legal)
    );

    ichram_seq #(.LAT(LATENCY)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .legal   (legal),
        .rd_req  (hw_data[F_DIR]),
        .busy    (busy),
        .ram_we  (ram_we),
        .rd_load (rd_load),
        .err_set (err_set)
    );

    // Latch the access fields when an access starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            bank_q <= '0;
            dir_q  <= 1'b0;
        end else if (start) begin
            chan_q <= hw_data[F_CHAN_LO +: CHW];
            bank_q <= hw_data[F_BANK_LO +: 2];
            dir_q  <= hw_data[F_DIR];
        end
    end

    // One RAM model per bank, write enable steered by the latched bank
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ichram_bank #(.DEPTH(NCH), .WIDTH(DW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (ram_we && (bank_q == 2'(b))),
            .addr  (chan_q),
            .wdata (data_q),
            .rdata (bank_rd[b])
        );
    end

    // Read data select by latched bank
    always_comb begin
        case (bank_q)
            2'd0:    rd_mux = bank_rd[0];
            2'd1:    rd_mux = bank_rd[1];
            2'd2:    rd_mux = bank_rd[2];
            default: rd_mux = '0;
        endcase
    end

    // Shared data register: host load when idle, RAM load at read finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_wr) begin
            data_q <= hw_data;
        end else if (rd_load) begin
            data_q <= rd_mux;
        end
    end

    // Sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end else if (eclr) begin
            err_q <= 1'b0;
        end
    end

    // Output assembly
    always_comb begin
        data_reg                   = data_q;
        err                        = err_q;
        ctrl_word                  = '0;
        ctrl_word[F_BUSY]          = busy;
        ctrl_word[F_DIR]           = dir_q;
        ctrl_word[F_ECLR]          = err_q;
        ctrl_word[F_BANK_LO +: 2]  = bank_q;
        ctrl_word[F_CHAN_LO +: CHW] = chan_q;
    end
endmodule

// File: rtl/ichram_ctrl_chk.sv
// Module: ichram_ctrl_chk
// Port-level protocol checker for ichram_ctrl, attached by bind.
module ichram_ctrl_chk
    import ichram_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          hw_en,
    input logic          hw_sel,
    input logic [DW-1:0] hw_data,
    input logic [DW-1:0] data_reg,
    input logic [DW-1:0] ctrl_word,
    input logic          busy,
    input logic          err
);
    logic [3:0] run_q;

    // Length of the present busy run
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && !hw_sel && !busy && !hw_data[F_ECLR]) |=> busy); // R4

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 4'(LATENCY))); // R6

    AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data_reg)); // R11

    AST_FIELDS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctrl_word[14:0] & 15'h47FF)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(hw_en && !hw_sel && !busy && hw_data[F_ECLR])) |=> err); // R10

    AST_BUSY_BIT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[F_BUSY] == busy); // R12
endmodule

bind ichram_ctrl ichram_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_en     (hw_en),
    .hw_sel    (hw_sel),
    .hw_data   (hw_data),
    .data_reg  (data_reg),
    .ctrl_word (ctrl_word),
    .busy      (busy),
    .err       (err)
);

// File: tb/ichram_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for ichram_ctrl: directed corners plus seeded random accesses,
// checked against a bench-side memory and range model.
module ichram_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_unch = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        hw_en = 1'b0;
    logic        hw_sel = 1'b0;
    logic [15:0] hw_data = '0;
    logic [15:0] data_reg;
    logic [15:0] ctrl_word;
    logic        busy;
    logic        err;

    int total = 0;
    int bad = 0;
    logic [15:0] mdl [3][128];
    logic [15:0] dmodel;

    ichram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_unch(mode_unch), .mode_sel(mode_sel),
        .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
        .data_reg(data_reg), .ctrl_word(ctrl_word), .busy(busy), .err(err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit legal_f(input logic u, input logic [1:0] s,
                                   input logic [1:0] b, input logic [6:0] c);
        int lim;
        if (u) lim = 0;
        else case (s)
            2'd0: lim = 24;
            2'd1: lim = 32;
            2'd2: lim = 64;
            default: lim = 128;
        endcase
        return (b != 2'd3) && (int'(c) < lim);
    endfunction

    function automatic logic [15:0] cw(input bit rd, input logic [1:0] b, input logic [6:0] c);
        return {1'b0, rd, 1'b0, 3'b0, b, 1'b0, c};
    endfunction

    task automatic host_wr(input bit sel, input logic [15:0] v);
        hw_en = 1'b1; hw_sel = sel; hw_data = v;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic set_data(input logic [15:0] v);
        host_wr(1'b1, v);
        dmodel = v;
        chk("R3 data load", data_reg, v);
    endtask

    task automatic clear_err();
        host_wr(1'b0, 16'h2000);
        chk("R10 clear", err, 1'b0);
        chk("R10 no start", busy, 1'b0);
    endtask

    // Run one access and check busy length, data, RAM model and err
    task automatic access(input bit rd, input logic [1:0] b, input logic [6:0] c);
        bit ok;
        int n;
        ok = legal_f(mode_unch, mode_sel, b, c);
        host_wr(1'b0, cw(rd, b, c));
        n = 0;
        while (busy && n < 20) begin
            n++;
            @(negedge clk);
        end
        if (ok) begin
            chk("R6 busy length", n, 3);
            if (rd) begin
                dmodel = mdl[b][c];
                chk("R7 read data", data_reg, dmodel);
            end else begin
                mdl[b][c] = dmodel;
                chk("R5 data held", data_reg, dmodel);
            end
            chk("R12 readback", ctrl_word, {1'b0, rd, 1'b0, 3'b0, b, 1'b0, c});
        end else begin
            chk("R9 busy length", n, 1);
            chk("R9 err set", err, 1'b1);
            chk("R9 data kept", data_reg, dmodel);
            clear_err();
        end
    endtask

    // Read back a word through the normal interface
    task automatic verify_word(input logic [1:0] b, input logic [6:0] c, input string req);
        logic [1:0] su; logic ss;
        ss = mode_unch; su = mode_sel;
        mode_unch = 1'b0; mode_sel = 2'd3;
        host_wr(1'b0, cw(1'b1, b, c));
        repeat (3) @(negedge clk);
        chk(req, data_reg, mdl[b][c]);
        dmodel = data_reg;
        mode_unch = ss; mode_sel = su;
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < 3; b++) for (int c = 0; c < 128; c++) mdl[b][c] = '0;
        dmodel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 1'b0);
        chk("R1 err", err, 1'b0);
        chk("R1 data", data_reg, 16'h0);
        mode_unch = 1'b0; mode_sel = 2'd3;
        access(1'b1, 2'd2, 7'd127);
        chk("R1 ram zero", data_reg, 16'h0);

        // Directed range edges per mode
        set_data(16'hA5A5);
        mode_sel = 2'd0; access(1'b0, 2'd0, 7'd23); access(1'b0, 2'd0, 7'd24);
        mode_sel = 2'd1; access(1'b0, 2'd1, 7'd31); access(1'b0, 2'd1, 7'd32);
        mode_sel = 2'd2; access(1'b0, 2'd2, 7'd63); access(1'b0, 2'd2, 7'd64);
        mode_sel = 2'd3; access(1'b0, 2'd0, 7'd127); access(1'b0, 2'd3, 7'd0);
        mode_unch = 1'b1; access(1'b0, 2'd0, 7'd0); access(1'b1, 2'd1, 7'd0);
        mode_unch = 1'b0;
        verify_word(2'd0, 7'd24, "R8 T1 edge untouched");
        verify_word(2'd2, 7'd63, "R8 4M edge written");
        verify_word(2'd1, 7'd32, "R9 no write");

        // Writes while busy are ignored
        set_data(16'h1111);
        mode_sel = 2'd3;
        hw_en = 1'b1; hw_sel = 1'b0; hw_data = cw(1'b0, 2'd1, 7'd5);
        @(negedge clk);
        hw_sel = 1'b1; hw_data = 16'h2222;
        @(negedge clk);
        hw_sel = 1'b0; hw_data = cw(1'b0, 2'd2, 7'd9);
        @(negedge clk);
        hw_en = 1'b0;
        @(negedge clk);
        mdl[1][5] = 16'h1111;
        chk("R11 data ignored", data_reg, 16'h1111);
        chk("R11 ctrl ignored", ctrl_word, cw(1'b0, 2'd1, 7'd5));
        verify_word(2'd1, 7'd5, "R11 access completed");
        verify_word(2'd2, 7'd9, "R11 second not run");

        // Sticky error survives non-clear writes
        access(1'b0, 2'd3, 7'd1);
        host_wr(1'b0, cw(1'b0, 2'd3, 7'd0));
        @(negedge clk);
        host_wr(1'b1, 16'h3333); dmodel = 16'h3333;
        chk("R10 sticky", err, 1'b1);
        clear_err();
        chk("R2 clear kept field", ctrl_word[9:8], 2'd3);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            mode_unch = ($urandom_range(0, 9) == 0);
            mode_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0) set_data(16'($urandom));
            access(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                   7'($urandom_range(0, 127)));
        end
        for (int i = 0; i < 40; i++)
            verify_word(2'($urandom_range(0, 2)), 7'($urandom_range(0, 127)), "R5 memory image");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule